// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block turns one high-level flash operation request into the ordered list of bus cycles that a separate NAND bus cycle engine carries out. The supported operations are device reset, identification read, status read, page read, page program and block erase. A request carries an operation code, a block number, a page number, a column offset and a byte count. The sequencer emits command, address, data-write and data-read cycles one at a time, each through a valid/acknowledge handshake. It watches the device ready line before the first command and after each command that starts internal device activity.

Program data comes in on a byte stream with a valid/ready handshake. Data read from the device leaves on a byte stream with a one-cycle valid strobe. Erase and program finish with an automatic status read, and that byte is returned on a status output together with the done pulse. A write-protect input that comes from a control register is copied to an active-low protect pin whenever the sequencer is idle. After each change, new requests are held off for a settling interval. Pin-level timing belongs to the cycle engine.

Top module: `nand_op_seq`

## Requirements
- R1: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `busy` is high from the cycle after acceptance up to and including the single cycle in which `done` is high, and it is low in the cycle after that. No bus cycle is requested while `busy` is low.
- R2: Every operation waits until `rb_ready` is high before it requests its first command cycle. While `rb_ready` stays low, no cycle is requested.
- R3: Operation code 0 (reset) requests a command cycle with 0xFF, waits for `rb_ready` high, then finishes.
- R4: Operation code 1 (identification) requests command 0x90, one address cycle with 0x00 and then exactly `ID_BYTES` (default 5) read cycles. Each read byte appears on `rd_data` with `rd_valid`.
- R5: Operation code 2 (status) requests command 0x70 and one read cycle. That byte appears on the read stream.
- R6: Operation code 3 (page read) requests command 0x00, four address cycles and command 0x30. It then waits for `rb_ready` and requests `req_count` read cycles, and each byte leaves on the read stream.
- R7: The four address bytes are sent in this order: column[7:0]; column[11:8] in bits 3:0 with bits 7:4 zero; {block[1:0], page[5:0]}; block[9:2].
- R8: Operation code 5 (block erase) requests command 0x60 and two address cycles, {block[1:0], 6'b0} and block[9:2]. It then requests command 0xD0, waits for `rb_ready`, and requests command 0x70 and one read cycle. That byte is presented on `status` with `done` and is not put on the read stream.
- R9: Operation code 4 (page program) requests command 0x80 and the four address cycles. It then requests `req_count` data-write cycles carrying the write-stream bytes in arrival order, and then command 0x10. After waiting for `rb_ready`, it requests command 0x70 and one read cycle whose byte is presented on `status` with `done`.
- R10: A `req_count` of zero skips the data phase of page read and page program, and both commands of the operation are still requested.
- R11: A requested cycle keeps `cyc_valid` high and `cyc_kind` and `cyc_data` unchanged until `cyc_ack` is seen. `cyc_kind` encodes command as 0, address as 1, data write as 2 and data read as 3.
- R12: `wp_n` takes the inverse of `wp_ctrl` only while no operation is in progress. After each change, `req_ready` stays low for exactly `WP_SETTLE` cycles.
- R13: Operation codes 6 and 7 are ignored. Requests presented while busy are ignored. Neither starts any bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request strobe |
| req_op | input | 3 | Operation code (0 reset, 1 id, 2 status, 3 read, 4 program, 5 erase) |
| req_block | input | BLK_W | Block number |
| req_page | input | PG_W | Page within block |
| req_col | input | COL_W | Column byte offset |
| req_count | input | CNT_W | Data byte count for read/program |
| req_ready | output | 1 | Sequencer can accept a request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 8 | Device status byte (erase and program) |
| cyc_valid | output | 1 | Bus cycle requested |
| cyc_kind | output | 2 | Cycle kind (0 cmd, 1 addr, 2 write, 3 read) |
| cyc_data | output | 8 | Byte for command/address/write cycles |
| cyc_ack | input | 1 | Cycle engine finished the cycle |
| cyc_rdata | input | 8 | Byte captured by a read cycle, valid with cyc_ack |
| rb_ready | input | 1 | Device ready (high) / busy (low) |
| wr_valid | input | 1 | Write stream byte available |
| wr_data | input | 8 | Write stream byte |
| wr_ready | output | 1 | Write stream byte taken |
| rd_valid | output | 1 | Read stream byte strobe |
| rd_data | output | 8 | Read stream byte |
| wp_ctrl | input | 1 | Write-protect request from control register |
| wp_n | output | 1 | Active-low write-protect pin |

## Verification
The hardest situations to reach from the ports are the ready-line waits, because the sequencer must hold back at the right point. The bench's cycle-engine model therefore pulls the ready line low for a random number of cycles after each command that starts device activity. The bench can also hold the line low before a request, which exercises the initial wait. A protect-pin change requested in the middle of an erase, and competing requests or illegal codes sent while busy, cover the rule that only an idle sequencer reacts. Random operations with random addresses, counts and engine latency are compared cycle by cycle against a list built by bench functions.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

   typedef enum logic [2:0] {
      OP_RESET  = 3'd0,
      OP_ID     = 3'd1,
      OP_STATUS = 3'd2,
      OP_READ   = 3'd3,
      OP_PROG   = 3'd4,
      OP_ERASE  = 3'd5
   } op_e;

   typedef enum logic [1:0] {
      CY_CMD   = 2'd0,
      CY_ADDR  = 2'd1,
      CY_WRITE = 2'd2,
      CY_READ  = 2'd3
   } cyc_e;

   localparam logic [7:0] STATUS_OPC = 8'h70;

   function automatic logic op_known(input logic [2:0] code);
      return code <= 3'd5;
   endfunction

   // opening opcode of each operation
   function automatic logic [7:0] lead_opc(input op_e op);
      case (op)
         OP_RESET:  return 8'hFF;
         OP_ID:     return 8'h90;
         OP_STATUS: return STATUS_OPC;
         OP_READ:   return 8'h00;
         OP_PROG:   return 8'h80;
         default:   return 8'h60;
      endcase
   endfunction

   // confirming opcode of two-command operations
   function automatic logic [7:0] trail_opc(input op_e op);
      case (op)
         OP_READ: return 8'h30;
         OP_PROG: return 8'h10;
         default: return 8'hD0;
      endcase
   endfunction

endpackage

// File: rtl/nand_seq_addr.sv
module nand_seq_addr #(
   parameter int COL_W = 12,
   parameter int PG_W  = 6,
   parameter int BLK_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [COL_W-1:0] col_in,
   input  logic [PG_W-1:0]  page_in,
   input  logic [BLK_W-1:0] blk_in,
   input  logic             zero_page,
   input  logic [1:0]       idx,
   output logic [7:0]       addr_byte
);
   localparam int ROW_W = PG_W + BLK_W;

   if (COL_W < 9 || COL_W > 16) begin : g_bad_col
      $error("COL_W must span two address bytes");
   end
   if (ROW_W > 16 || PG_W > 7) begin : g_bad_row
      $error("row address must fit two address bytes");
   end

   logic [COL_W-1:0] col_q;
   logic [PG_W-1:0]  page_q;
   logic [BLK_W-1:0] blk_q;
   logic [15:0]      col16;
   logic [15:0]      row16;
   logic [PG_W-1:0]  page_eff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q  <= '0;
         page_q <= '0;
         blk_q  <= '0;
      end else if (load) begin
         col_q  <= col_in;
         page_q <= page_in;
         blk_q  <= blk_in;
      end
   end

   always_comb begin
      page_eff = zero_page ? '0 : page_q;
      col16    = 16'(col_q);
      row16    = 16'({blk_q, page_eff});
      case (idx)
         2'd0:    addr_byte = col16[7:0];
         2'd1:    addr_byte = col16[15:8];
         2'd2:    addr_byte = row16[7:0];
         default: addr_byte = row16[15:8];
      endcase
   end

endmodule

// File: rtl/nand_seq_wp.sv
module nand_seq_wp #(
   parameter int WP_SETTLE = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wp_ctrl,
   input  logic idle,
   output logic wp_n,
   output logic settled
);
   logic wp_q;
   logic apply;

   assign apply = idle && (wp_ctrl != wp_q);
   assign wp_n  = ~wp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     wp_q <= 1'b0;
      else if (apply) wp_q <= wp_ctrl;
   end

   if (WP_SETTLE == 0) begin : g_no_settle
      assign settled = (wp_ctrl == wp_q);
   end else begin : g_settle
      localparam int SW = $clog2(WP_SETTLE + 1);
      logic [SW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              cnt_q <= '0;
         else if (apply)          cnt_q <= SW'(WP_SETTLE);
         else if (cnt_q != '0)    cnt_q <= cnt_q - SW'(1);
      end

      assign settled = (cnt_q == '0) && (wp_ctrl == wp_q);

      // R12: a pin change is always followed by a hold-off
      p_wp_settle_r12: assert property (@(posedge clk) disable iff (!rst_n)
         (wp_n != $past(wp_n)) |-> !settled);
   end

endmodule

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
   import nand_seq_pkg::*;
#(
   parameter int CNT_W    = 13,
   parameter int ID_BYTES = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [2:0]       req_op,
   input  logic [CNT_W-1:0] req_count,
   input  logic             settled,
   output logic             req_ready,
   output logic             req_take,
   output logic             busy,
   output logic             done,
   output logic [7:0]       status,
   output logic             cyc_valid,
   output logic [1:0]       cyc_kind,
   output logic [7:0]       cyc_data,
   input  logic             cyc_ack,
   input  logic [7:0]       cyc_rdata,
   input  logic             rb_ready,
   input  logic             wr_valid,
   input  logic [7:0]       wr_data,
   output logic             wr_ready,
   output logic             rd_valid,
   output logic [7:0]       rd_data,
   output logic [1:0]       addr_idx,
   output logic             addr_zero_page,
   input  logic [7:0]       addr_byte
);
   if (ID_BYTES < 1 || ID_BYTES >= (1 << CNT_W)) begin : g_bad_id
      $error("ID_BYTES must be nonzero and fit CNT_W");
   end

   typedef enum logic [3:0] {
      PH_IDLE, PH_PRE, PH_CMD1, PH_ADDR, PH_DATA, PH_CMD2,
      PH_POST, PH_RDATA, PH_STCMD, PH_STRD, PH_DONE
   } phase_e;

   phase_e           phase;
   op_e              op_q;
   logic [CNT_W-1:0] remain;
   logic [1:0]       idx_q;
   logic             pend;
   cyc_e             kind_q;
   logic [7:0]       data_q;
   logic [7:0]       status_q;
   logic             rd_valid_q;
   logic [7:0]       rd_data_q;

   cyc_e             lk;
   logic [7:0]       ld;
   logic             launch_ph;
   logic             launch;
   logic             acked;
   logic [1:0]       last_idx;

   assign req_ready      = (phase == PH_IDLE) && settled;
   assign req_take       = req_valid && req_ready && op_known(req_op);
   assign busy           = (phase != PH_IDLE);
   assign done           = (phase == PH_DONE);
   assign status         = status_q;
   assign cyc_valid      = pend;
   assign cyc_kind       = kind_q;
   assign cyc_data       = data_q;
   assign wr_ready       = (phase == PH_DATA) && !pend;
   assign rd_valid       = rd_valid_q;
   assign rd_data        = rd_data_q;
   assign addr_idx       = idx_q;
   assign addr_zero_page = (op_q == OP_ERASE);
   assign acked          = pend && cyc_ack;
   assign last_idx       = (op_q == OP_ID) ? 2'd0 : 2'd3;

   // next cycle to request in the current phase
   always_comb begin
      lk        = CY_CMD;
      ld        = 8'h00;
      launch_ph = 1'b1;
      case (phase)
         PH_CMD1:  ld = lead_opc(op_q);
         PH_ADDR:  begin lk = CY_ADDR; ld = (op_q == OP_ID) ? 8'h00 : addr_byte; end
         PH_DATA:  begin lk = CY_WRITE; ld = wr_data; launch_ph = wr_valid; end
         PH_CMD2:  ld = trail_opc(op_q);
         PH_STCMD: ld = STATUS_OPC;
         PH_STRD, PH_RDATA: lk = CY_READ;
         default:  launch_ph = 1'b0;
      endcase
   end
   assign launch = !pend && launch_ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         op_q       <= OP_RESET;
         remain     <= '0;
         idx_q      <= '0;
         pend       <= 1'b0;
         kind_q     <= CY_CMD;
         data_q     <= '0;
         status_q   <= '0;
         rd_valid_q <= 1'b0;
         rd_data_q  <= '0;
      end else begin
         rd_valid_q <= 1'b0;
         if (launch) begin
            pend   <= 1'b1;
            kind_q <= lk;
            data_q <= ld;
         end
         if (acked) pend <= 1'b0;
         case (phase)
            PH_IDLE: if (req_take) begin
               op_q   <= op_e'(req_op);
               remain <= req_count;
               phase  <= PH_PRE;
            end
            PH_PRE: if (rb_ready) phase <= PH_CMD1;
            PH_CMD1: if (acked) begin
               case (op_q)
                  OP_RESET:  phase <= PH_POST;
                  OP_STATUS: begin remain <= CNT_W'(1); phase <= PH_RDATA; end
                  OP_ERASE:  begin idx_q <= 2'd2; phase <= PH_ADDR; end
                  default:   begin idx_q <= 2'd0; phase <= PH_ADDR; end
               endcase
            end
            PH_ADDR: if (acked) begin
               if (idx_q == last_idx) begin
                  if (op_q == OP_ID) begin
                     remain <= CNT_W'(ID_BYTES);
                     phase  <= PH_RDATA;
                  end else if (op_q == OP_PROG && remain != '0) begin
                     phase <= PH_DATA;
                  end else begin
                     phase <= PH_CMD2;
                  end
               end else begin
                  idx_q <= idx_q + 2'd1;
               end
            end
            PH_DATA: if (acked) begin
               remain <= remain - CNT_W'(1);
               if (remain == CNT_W'(1)) phase <= PH_CMD2;
            end
            PH_CMD2:  if (acked) phase <= PH_POST;
            PH_POST: if (rb_ready) begin
               case (op_q)
                  OP_RESET: phase <= PH_DONE;
                  OP_READ:  phase <= (remain == '0) ? PH_DONE : PH_RDATA;
                  default:  phase <= PH_STCMD;
               endcase
            end
            PH_STCMD: if (acked) phase <= PH_STRD;
            PH_STRD: if (acked) begin
               status_q <= cyc_rdata;
               phase    <= PH_DONE;
            end
            PH_RDATA: if (acked) begin
               rd_valid_q <= 1'b1;
               rd_data_q  <= cyc_rdata;
               remain     <= remain - CNT_W'(1);
               if (remain == CNT_W'(1)) phase <= PH_DONE;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // R11: requested cycle is held steady until acknowledged
   p_cyc_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_valid && !cyc_ack) |=> (cyc_valid && $stable(cyc_kind) && $stable(cyc_data)));

   // R1: no bus activity outside an operation
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !cyc_valid);

   // R1: done is a single pulse that closes the operation
   p_done_close_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!busy && !done));

   // R13: no acceptance while an operation runs
   p_busy_block_r13: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !req_ready);

   // R4: read stream only during an operation
   p_rd_in_op_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> busy);

endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq #(
   parameter int CNT_W     = 13,
   parameter int ID_BYTES  = 5,
   parameter int WP_SETTLE = 8,
   parameter int COL_W     = 12,
   parameter int PG_W      = 6,
   parameter int BLK_W     = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [2:0]       req_op,
   input  logic [BLK_W-1:0] req_block,
   input  logic [PG_W-1:0]  req_page,
   input  logic [COL_W-1:0] req_col,
   input  logic [CNT_W-1:0] req_count,
   output logic             req_ready,
   output logic             busy,
   output logic             done,
   output logic [7:0]       status,
   output logic             cyc_valid,
   output logic [1:0]       cyc_kind,
   output logic [7:0]       cyc_data,
   input  logic             cyc_ack,
   input  logic [7:0]       cyc_rdata,
   input  logic             rb_ready,
   input  logic             wr_valid,
   input  logic [7:0]       wr_data,
   output logic             wr_ready,
   output logic             rd_valid,
   output logic [7:0]       rd_data,
   input  logic             wp_ctrl,
   output logic             wp_n
);
   logic       settled;
   logic       req_take;
   logic [1:0] addr_idx;
   logic       addr_zero_page;
   logic [7:0] addr_byte;

   nand_seq_wp #(.WP_SETTLE(WP_SETTLE)) wp_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wp_ctrl (wp_ctrl),
      .idle    (!busy),
      .wp_n    (wp_n),
      .settled (settled)
   );

   nand_seq_addr #(.COL_W(COL_W), .PG_W(PG_W), .BLK_W(BLK_W)) addr_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (req_take),
      .col_in    (req_col),
      .page_in   (req_page),
      .blk_in    (req_block),
      .zero_page (addr_zero_page),
      .idx       (addr_idx),
      .addr_byte (addr_byte)
   );

   nand_seq_ctrl #(.CNT_W(CNT_W), .ID_BYTES(ID_BYTES)) ctrl_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_valid      (req_valid),
      .req_op         (req_op),
      .req_count      (req_count),
      .settled        (settled),
      .req_ready      (req_ready),
      .req_take       (req_take),
      .busy           (busy),
      .done           (done),
      .status         (status),
      .cyc_valid      (cyc_valid),
      .cyc_kind       (cyc_kind),
      .cyc_data       (cyc_data),
      .cyc_ack        (cyc_ack),
      .cyc_rdata      (cyc_rdata),
      .rb_ready       (rb_ready),
      .wr_valid       (wr_valid),
      .wr_data        (wr_data),
      .wr_ready       (wr_ready),
      .rd_valid       (rd_valid),
      .rd_data        (rd_data),
      .addr_idx       (addr_idx),
      .addr_zero_page (addr_zero_page),
      .addr_byte      (addr_byte)
   );

endmodule

// File: tb/nand_op_seq_tb_top.sv
module nand_op_seq_tb_top;
   localparam int CNT_W = 13;
   localparam int SETTLE = 8;
   localparam int LOGN = 4096;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        req_valid = 1'b0;
   logic [2:0]  req_op = '0;
   logic [9:0]  req_block = '0;
   logic [5:0]  req_page = '0;
   logic [11:0] req_col = '0;
   logic [CNT_W-1:0] req_count = '0;
   logic        req_ready, busy, done, cyc_valid, wr_ready, rd_valid, wp_n;
   logic [7:0]  status, cyc_data, rd_data, wr_data;
   logic [1:0]  cyc_kind;
   logic        cyc_ack;
   logic [7:0]  cyc_rdata;
   logic        rb_ready;
   logic        wp_ctrl = 1'b0;
   logic        ext_hold = 1'b0;

   // engine / device model state
   logic [1:0]  lk [LOGN];
   logic [7:0]  ldat [LOGN];
   logic [7:0]  rdl [LOGN];
   logic [7:0]  wbuf [LOGN];
   int log_n, rd_n, wr_idx, viol, lat, busy_cnt;
   logic [7:0] rseq;

   assign rb_ready = !ext_hold && (busy_cnt == 0);
   assign wr_data  = wbuf[wr_idx % LOGN];

   nand_op_seq dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_block(req_block), .req_page(req_page), .req_col(req_col),
      .req_count(req_count), .req_ready(req_ready), .busy(busy), .done(done),
      .status(status), .cyc_valid(cyc_valid), .cyc_kind(cyc_kind),
      .cyc_data(cyc_data), .cyc_ack(cyc_ack), .cyc_rdata(cyc_rdata),
      .rb_ready(rb_ready), .wr_valid(1'b1), .wr_data(wr_data),
      .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_data(rd_data),
      .wp_ctrl(wp_ctrl), .wp_n(wp_n)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_ack <= 1'b0; cyc_rdata <= '0; log_n <= 0; rd_n <= 0; wr_idx <= 0;
         viol <= 0; lat <= 0; busy_cnt <= 0; rseq <= 8'd0;
      end else begin
         cyc_ack <= 1'b0;
         if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
         if (cyc_valid && !cyc_ack) begin
            if (!rb_ready) viol <= viol + 1;
            if (lat == 0) begin
               cyc_ack <= 1'b1;
               lk[log_n % LOGN] <= cyc_kind;
               if (cyc_kind == 2'd3) begin
                  cyc_rdata <= rseq * 8'd29 + 8'd7;
                  ldat[log_n % LOGN] <= rseq * 8'd29 + 8'd7;
                  rseq <= rseq + 8'd1;
               end else begin
                  ldat[log_n % LOGN] <= cyc_data;
               end
               log_n <= log_n + 1;
               if (cyc_kind == 2'd0 && (cyc_data == 8'hFF || cyc_data == 8'h30 ||
                   cyc_data == 8'hD0 || cyc_data == 8'h10))
                  busy_cnt <= 2 + int'($urandom % 5);
               lat <= int'($urandom % 3);
            end else begin
               lat <= lat - 1;
            end
         end
         if (rd_valid) begin
            rdl[rd_n % LOGN] <= rd_data;
            rd_n <= rd_n + 1;
         end
         if (wr_ready) wr_idx <= wr_idx + 1;
      end
   end

   int n_checks = 0, n_fail = 0, cyc_cnt = 0;
   bit abort = 0;
   always @(posedge clk) begin
      cyc_cnt <= cyc_cnt + 1;
      if (cyc_cnt == 190000) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc_cnt, 0);
         $display("  TB_RESULT checks=%0d failures=%0d", n_checks + 1, n_fail);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // current operation and expected cycle list
   int cur_op, cur_blk, cur_pg, cur_col, cur_cnt;
   int log_base, rd_base, wr_base;
   logic [1:0] ek [LOGN];
   logic [7:0] ed [LOGN];
   int n_exp;

   task automatic push(input logic [1:0] k, input logic [7:0] d);
      ek[n_exp] = k; ed[n_exp] = d; n_exp++;
   endtask

   task automatic push_addr4();
      push(2'd1, 8'(cur_col & 255));
      push(2'd1, 8'((cur_col >> 8) & 15));
      push(2'd1, 8'(((cur_blk & 3) << 6) | cur_pg));
      push(2'd1, 8'(cur_blk >> 2));
   endtask

   task automatic build_exp();
      n_exp = 0;
      case (cur_op)
         0: push(2'd0, 8'hFF);
         1: begin push(2'd0, 8'h90); push(2'd1, 8'h00);
               for (int i = 0; i < 5; i++) push(2'd3, 8'h00); end
         2: begin push(2'd0, 8'h70); push(2'd3, 8'h00); end
         3: begin push(2'd0, 8'h00); push_addr4(); push(2'd0, 8'h30);
               for (int i = 0; i < cur_cnt; i++) push(2'd3, 8'h00); end
         4: begin push(2'd0, 8'h80); push_addr4();
               for (int i = 0; i < cur_cnt; i++) push(2'd2, wbuf[(wr_base + i) % LOGN]);
               push(2'd0, 8'h10); push(2'd0, 8'h70); push(2'd3, 8'h00); end
         default: begin push(2'd0, 8'h60);
               push(2'd1, 8'((cur_blk & 3) << 6)); push(2'd1, 8'(cur_blk >> 2));
               push(2'd0, 8'hD0); push(2'd0, 8'h70); push(2'd3, 8'h00); end
      endcase
   endtask

   function automatic string op_req(input int op);
      case (op)
         0: return "R3";
         1: return "R4";
         2: return "R5";
         3: return "R6/R7";
         4: return "R9/R7";
         default: return "R8";
      endcase
   endfunction

   task automatic start_op(input int op, input int blk, input int pg,
                           input int col, input int cnt);
      int t;
      t = 0;
      @(negedge clk);
      while (!req_ready && t < 2000) begin @(negedge clk); t++; end
      if (t >= 2000) begin
         check(0, "R1", "req_ready timeout", 0, 1); abort = 1; return;
      end
      cur_op = op; cur_blk = blk; cur_pg = pg; cur_col = col; cur_cnt = cnt;
      log_base = log_n; rd_base = rd_n; wr_base = wr_idx;
      req_op = 3'(op); req_block = 10'(blk); req_page = 6'(pg);
      req_col = 12'(col); req_count = CNT_W'(cnt); req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check(busy == 1'b1, "R1", "busy after accept", int'(busy), 1);
   endtask

   task automatic wait_done(output logic [7:0] st);
      int t;
      t = 0;
      st = 8'h00;
      while (!done && t < 5000) begin @(negedge clk); t++; end
      if (t >= 5000) begin
         check(0, "R1", "done timeout", 0, 1); abort = 1; return;
      end
      st = status;
      @(negedge clk);
      check(busy == 1'b0 && done == 1'b0, "R1", "idle after done",
            int'({busy, done}), 0);
   endtask

   task automatic verify(input logic [7:0] st);
      int mism, got, rdexp, rdm, lastrd;
      string rq;
      rq = op_req(cur_op);
      build_exp();
      got = log_n - log_base;
      check(got == n_exp, rq, "bus cycle count", got, n_exp);
      mism = 0; rdexp = 0; rdm = 0; lastrd = 0;
      for (int i = 0; i < n_exp && i < got; i++) begin
         if (lk[(log_base + i) % LOGN] != ek[i]) mism++;
         else if (ek[i] != 2'd3 && ldat[(log_base + i) % LOGN] != ed[i]) mism++;
         if (ek[i] == 2'd3) begin
            lastrd = int'(ldat[(log_base + i) % LOGN]);
            if (cur_op != 4 && cur_op != 5) begin
               if (rdl[(rd_base + rdexp) % LOGN] != ldat[(log_base + i) % LOGN]) rdm++;
               rdexp++;
            end
         end
      end
      check(mism == 0, rq, "bus cycle kind/byte mismatches", mism, 0);
      check(rd_n - rd_base == rdexp, rq, "read stream length", rd_n - rd_base, rdexp);
      check(rdm == 0, rq, "read stream byte mismatches", rdm, 0);
      if (cur_op == 4 || cur_op == 5)
         check(int'(st) == lastrd, rq, "returned status byte", int'(st), lastrd);
      if (cur_op == 4)
         check(wr_idx - wr_base == cur_cnt, "R9", "write bytes consumed",
               wr_idx - wr_base, cur_cnt);
      check(viol == 0, "R2", "cycles requested while not ready", viol, 0);
   endtask

   task automatic run_op(input int op, input int blk, input int pg,
                         input int col, input int cnt);
      logic [7:0] st;
      start_op(op, blk, pg, col, cnt);
      if (abort) return;
      wait_done(st);
      if (abort) return;
      verify(st);
   endtask

   initial begin
      logic [7:0] st;
      int base, lows;
      void'($urandom(32'd1357));
      for (int i = 0; i < LOGN; i++) wbuf[i] = 8'($urandom);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      check(busy == 0 && done == 0 && cyc_valid == 0, "R1", "reset outputs idle",
            int'({busy, done, cyc_valid}), 0);
      check(req_ready == 1 && wp_n == 1, "R12", "reset ready and pin",
            int'({req_ready, wp_n}), 3);

      // directed operations
      run_op(0, 0, 0, 0, 0);                       // R3
      run_op(1, 0, 0, 0, 0);                       // R4
      run_op(2, 0, 0, 0, 0);                       // R5
      run_op(3, 517, 33, 12'hA5C, 3);              // R6, R7
      run_op(3, 1023, 63, 4095, 2);                // R7 extremes
      run_op(3, 9, 1, 7, 0);                       // R10 read with zero count
      run_op(5, 1023, 63, 4095, 0);                // R8 page bits forced zero
      run_op(4, 2, 5, 300, 4);                     // R9
      run_op(4, 700, 17, 2049, 0);                 // R10 program with zero count

      // R2: hold ready low before a request
      ext_hold = 1'b1;
      start_op(2, 0, 0, 0, 0);
      base = log_n;
      repeat (15) @(negedge clk);
      check(log_n == base && busy == 1, "R2", "no cycle while not ready",
            log_n - base, 0);
      ext_hold = 1'b0;
      wait_done(st);
      verify(st);

      // R13: illegal code ignored
      @(negedge clk);
      base = log_n;
      req_op = 3'd6; req_valid = 1'b1;
      repeat (2) @(negedge clk);
      req_op = 3'd7;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (3) @(negedge clk);
      check(busy == 0 && log_n == base, "R13", "illegal code ignored",
            int'(busy) + log_n - base, 0);

      // R13: competing request while busy ignored
      start_op(1, 0, 0, 0, 0);
      req_op = 3'd0; req_valid = 1'b1;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
      wait_done(st);
      verify(st);
      base = log_n;
      repeat (10) @(negedge clk);
      check(busy == 0 && log_n == base, "R13", "request during busy dropped",
            log_n - base, 0);

      // R12: protect change and settle window
      wp_ctrl = 1'b1;
      lows = 0;
      @(negedge clk);
      check(wp_n == 1'b0, "R12", "pin follows control", int'(wp_n), 0);
      if (!req_ready) lows++;
      for (int i = 0; i < SETTLE + 4; i++) begin
         @(negedge clk);
         if (!req_ready) lows++;
      end
      check(lows == SETTLE, "R12", "settle cycles", lows, SETTLE);

      // R12: change during an operation waits for idle
      start_op(5, 300, 0, 0, 0);
      wp_ctrl = 1'b0;
      repeat (3) @(negedge clk);
      check(wp_n == 1'b0 && busy == 1, "R12", "pin held while busy",
            int'(wp_n), 0);
      wait_done(st);
      verify(st);
      @(negedge clk);
      check(wp_n == 1'b1, "R12", "pin applied once idle", int'(wp_n), 1);

      // constrained random operations
      for (int n = 0; n < 24 && !abort; n++) begin
         int op, cnt;
         op  = int'($urandom % 6);
         cnt = ($urandom % 4 == 0) ? 0 : int'($urandom % 9);
         run_op(op, int'($urandom % 1024), int'($urandom % 64),
                int'($urandom % 4096), cnt);
      end

      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule